// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host's byte-wide write and read strobes and the controller of a flash array. It watches each accepted write, follows the multi-cycle unlock protocol, and when a complete and valid command has arrived it raises a one-cycle start pulse for byte program, page erase or chip erase. Each pulse carries the latched target address, the program byte and a per-page erase mask. Any write that breaks a sequence drops the decoder back to its idle read state, and nothing starts.

Two 16 KB boot areas, one at the lowest and one at the highest addresses, can each be locked by a seven-cycle command. The lock bits behave as non-volatile state. A normal reset leaves them alone, and only a dedicated clear input erases them. Program and page erase aimed at a locked area are dropped. A chip erase still runs, but its mask leaves out the locked pages. An identification mode answers reads with a manufacturer code, a device code and the two lock flags. Write strobes are assumed to be synchronous to the clock already. The embedded operation reports through the busy input, and writes that arrive while it is high are discarded.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A synchronous reset clears the sequence state, the identification flag, all start pulses, op_addr, op_data, erase_mask and the read outputs. After reset, a lone data write starts nothing.
- R2: The four accepted writes AA@5555, 55@2AAA, A0@5555 and then (A, D) give prog_start=1 in the cycle after the fourth write, with op_addr=A and op_data=D. Only address bits 14:0 are compared against 5555 and 2AAA.
- R3: The six writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555 give chip_erase_start=1 one cycle later. erase_mask then has a 1 for every page that is not inside a locked boot area and op_addr=0. The page index is address bits 16:12. The bottom area is pages 0 to 3 and the top area is pages 28 to 31.
- R4: The same five-write prefix followed by data 50 at any address A gives page_erase_start=1 one cycle later, with op_addr=A and erase_mask one-hot at page A[16:12].
- R5: The prefix followed by 70@5555 and a seventh write sets a lock. A seventh write to 1FFFF sets the top lock and a seventh write to 00000 sets the bottom lock. Any other seventh address sets nothing.
- R6: A write whose address or data does not match the expected step returns the decoder to idle and starts nothing. A new command needs the full sequence again.
- R7: Writes accepted while busy=1 are ignored and leave the sequence state and identification flag unchanged.
- R8: The write 90@5555 as the third cycle enters identification mode (id_mode=1). A read with address bits 7:0 equal to 00 returns DA and one with bits 7:0 equal to 01 returns A1. Other addresses return 00. The answer appears one cycle after rd_en with rd_valid=1. Outside identification mode rd_valid stays 0. A read in the same cycle as a write is answered from the state before that write.
- R9: In identification mode, a read at 00002 returns the bottom lock flag in bits 1 and 0, and a read at 1FFF2 returns the top lock flag in bits 1 and 0. All other bits are 0.
- R10: Identification mode is left by AA@5555, 55@2AAA, F0@5555, or by a single write of F0 to any address while no sequence is in progress.
- R11: A program or page erase whose target page lies in a locked area produces no start pulse.
- R12: Lock flags survive rst. Only lock_clr clears them.
- R13: At most one start pulse is high in any cycle, and each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (locks kept) |
| lock_clr | input | 1 | Clears both boot lock flags |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data |
| busy | input | 1 | Embedded operation in progress |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 17 | Read address |
| prog_start | output | 1 | Byte program start pulse |
| chip_erase_start | output | 1 | Chip erase start pulse |
| page_erase_start | output | 1 | Page erase start pulse |
| op_addr | output | 17 | Target address of the started operation |
| op_data | output | 8 | Byte to program |
| erase_mask | output | 32 | Pages to erase, one bit per 4 KB page |
| id_mode | output | 1 | Identification mode active |
| rd_valid | output | 1 | Identification read answer valid |
| rd_data | output | 8 | Identification read answer |

## Verification
Two functions can fall in the same cycle: the write that finishes a lock command or leaves identification mode, and an identification read. The bench provokes this by raising rd_en in the very cycle of the seventh lock write and in the cycle of the single-write exit. It expects the lock status from before the write in the first case, and a valid manufacturer code in the second. A follow-up read then has to show the new lock flag, or no valid answer at all. A random stream of program and erase commands also mixes in corrupted cycles and ignored writes during busy, with the boot locks set in some phases.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int CMD_AW = 15;

  localparam logic [CMD_AW-1:0] CA_FIRST  = 15'h5555;
  localparam logic [CMD_AW-1:0] CA_SECOND = 15'h2AAA;

  localparam logic [BYTE_W-1:0] K_UNLOCK_A = 8'hAA;
  localparam logic [BYTE_W-1:0] K_UNLOCK_B = 8'h55;
  localparam logic [BYTE_W-1:0] K_PROG     = 8'hA0;
  localparam logic [BYTE_W-1:0] K_SETUP    = 8'h80;
  localparam logic [BYTE_W-1:0] K_IDENT    = 8'h90;
  localparam logic [BYTE_W-1:0] K_CHIP     = 8'h10;
  localparam logic [BYTE_W-1:0] K_PAGE     = 8'h50;
  localparam logic [BYTE_W-1:0] K_LOCK     = 8'h70;
  localparam logic [BYTE_W-1:0] K_EXIT     = 8'hF0;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PROG, SQ_SETUP, SQ_UNL3, SQ_UNL4, SQ_LOCK
  } seq_state_t;

  typedef struct packed {
    logic prog;
    logic chip;
    logic page;
    logic lock_top;
    logic lock_bot;
  } seq_evt_t;
endpackage

// File: rtl/fcs_seq.sv
module fcs_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              busy,
  output seq_evt_t          evt,
  output logic              id_mode
);
  seq_state_t state_q, state_d;
  logic       id_d;
  logic       take;
  logic       at_first, at_second;

  assign take      = wr_en && !busy;
  assign at_first  = (wr_addr[CMD_AW-1:0] == CA_FIRST);
  assign at_second = (wr_addr[CMD_AW-1:0] == CA_SECOND);

  always_comb begin
    state_d = state_q;
    id_d    = id_mode;
    evt     = '0;
    if (take) begin
      state_d = SQ_IDLE;
      unique case (state_q)
        SQ_IDLE: begin
          if (id_mode && wr_data == K_EXIT) id_d = 1'b0;
          else if (at_first && wr_data == K_UNLOCK_A) state_d = SQ_UNL1;
        end
        SQ_UNL1: if (at_second && wr_data == K_UNLOCK_B) state_d = SQ_UNL2;
        SQ_UNL2: begin
          if (at_first) begin
            case (wr_data)
              K_PROG:  state_d = SQ_PROG;
              K_SETUP: state_d = SQ_SETUP;
              K_IDENT: id_d = 1'b1;
              K_EXIT:  id_d = 1'b0;
              default: state_d = SQ_IDLE;
            endcase
          end
        end
        SQ_PROG:  evt.prog = 1'b1;
        SQ_SETUP: if (at_first && wr_data == K_UNLOCK_A) state_d = SQ_UNL3;
        SQ_UNL3:  if (at_second && wr_data == K_UNLOCK_B) state_d = SQ_UNL4;
        SQ_UNL4: begin
          if (at_first && wr_data == K_CHIP)      evt.chip = 1'b1;
          else if (wr_data == K_PAGE)             evt.page = 1'b1;
          else if (at_first && wr_data == K_LOCK) state_d = SQ_LOCK;
        end
        SQ_LOCK: begin
          if (wr_addr == '1)      evt.lock_top = 1'b1;
          else if (wr_addr == '0) evt.lock_bot = 1'b1;
        end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      id_mode <= 1'b0;
    end else begin
      state_q <= state_d;
      id_mode <= id_d;
    end
  end

  // R7: a write during busy changes neither sequence state nor id flag
  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> (state_q == $past(state_q) && id_mode == $past(id_mode)));

  // R6: a wrong second unlock cycle drops back to idle
  assert_abort_R6: assert property (@(posedge clk) disable iff (rst)
    (take && state_q == SQ_UNL1 && !at_second) |=> (state_q == SQ_IDLE));

  // R10: a single exit byte from idle always leaves identification mode
  assert_exit_R10: assert property (@(posedge clk) disable iff (rst)
    (take && state_q == SQ_IDLE && wr_data == K_EXIT) |=> !id_mode);
endmodule

// File: rtl/fcs_guard.sv
module fcs_guard
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int PAGE_AW = 12,
  parameter int BOOT_AW = 14,
  localparam int PG_W   = ADDR_W - PAGE_AW,
  localparam int NPAGE  = 1 << PG_W,
  localparam int NBOOT  = 1 << (BOOT_AW - PAGE_AW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_clr,
  input  seq_evt_t          evt,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              prog_start,
  output logic              chip_start,
  output logic              page_start,
  output logic [ADDR_W-1:0] op_addr,
  output logic [BYTE_W-1:0] op_data,
  output logic [NPAGE-1:0]  erase_mask,
  output logic              lock_top,
  output logic              lock_bot
);
  logic [NPAGE-1:0] locked_vec;
  logic [NPAGE-1:0] page_onehot;
  logic [PG_W-1:0]  tgt_page;
  logic             tgt_locked;
  logic             fire_prog, fire_page, fire_chip;

  for (genvar p = 0; p < NPAGE; p++) begin : g_page
    if (p < NBOOT) begin : g_bot
      assign locked_vec[p] = lock_bot;
    end else if (p >= NPAGE - NBOOT) begin : g_top
      assign locked_vec[p] = lock_top;
    end else begin : g_mid
      assign locked_vec[p] = 1'b0;
    end
    assign page_onehot[p] = (tgt_page == PG_W'(p));
  end

  assign tgt_page   = wr_addr[ADDR_W-1:PAGE_AW];
  assign tgt_locked = locked_vec[tgt_page];
  assign fire_prog  = evt.prog && !tgt_locked;
  assign fire_page  = evt.page && !tgt_locked;
  assign fire_chip  = evt.chip;

  always_ff @(posedge clk) begin
    if (lock_clr) begin
      lock_top <= 1'b0;
      lock_bot <= 1'b0;
    end else begin
      if (evt.lock_top) lock_top <= 1'b1;
      if (evt.lock_bot) lock_bot <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_start <= 1'b0;
      chip_start <= 1'b0;
      page_start <= 1'b0;
      op_addr    <= '0;
      op_data    <= '0;
      erase_mask <= '0;
    end else begin
      prog_start <= fire_prog;
      chip_start <= fire_chip;
      page_start <= fire_page;
      if (fire_prog) begin
        op_addr    <= wr_addr;
        op_data    <= wr_data;
        erase_mask <= '0;
      end else if (fire_page) begin
        op_addr    <= wr_addr;
        op_data    <= '0;
        erase_mask <= page_onehot;
      end else if (fire_chip) begin
        op_addr    <= '0;
        op_data    <= '0;
        erase_mask <= ~locked_vec;
      end
    end
  end

  // R11: a started program never targets a locked page
  assert_prog_unlocked_R11: assert property (@(posedge clk) disable iff (rst)
    prog_start |-> !locked_vec[op_addr[ADDR_W-1:PAGE_AW]]);

  // R3: chip erase mask skips every locked page
  assert_chip_skip_R3: assert property (@(posedge clk) disable iff (rst)
    chip_start |-> ((erase_mask & locked_vec) == '0));

  // R4: page erase selects exactly one page, the one addressed
  assert_page_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    page_start |-> ($onehot(erase_mask) && erase_mask[op_addr[ADDR_W-1:PAGE_AW]]));

  // R13: start pulses are exclusive and one cycle long
  assert_pulse_excl_R13: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_start, chip_start, page_start}));
  assert_pulse_short_R13: assert property (@(posedge clk) disable iff (rst)
    (prog_start || chip_start || page_start) |=> !(prog_start || chip_start || page_start));

  // R12: lock flags only fall through lock_clr
  assert_lock_sticky_R12: assert property (@(posedge clk) disable iff (lock_clr)
    (lock_top && lock_bot) |=> (lock_top && lock_bot));
  assert_top_sticky_R12: assert property (@(posedge clk) disable iff (lock_clr)
    lock_top |=> lock_top);
endmodule

// File: rtl/fcs_idread.sv
module fcs_idread
  import flash_cmd_pkg::*;
#(
  parameter int               ADDR_W   = 17,
  parameter logic [BYTE_W-1:0] MFR_CODE = 8'hDA,
  parameter logic [BYTE_W-1:0] DEV_CODE = 8'hA1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              id_mode,
  input  logic              lock_top,
  input  logic              lock_bot,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] BOT_STAT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] TOP_STAT = {{(ADDR_W-4){1'b1}}, 4'h2};

  logic [BYTE_W-1:0] answer;

  always_comb begin
    answer = '0;
    if (rd_addr == BOT_STAT)         answer = {{(BYTE_W-2){1'b0}}, lock_bot, lock_bot};
    else if (rd_addr == TOP_STAT)    answer = {{(BYTE_W-2){1'b0}}, lock_top, lock_top};
    else if (rd_addr[7:0] == 8'h00)  answer = MFR_CODE;
    else if (rd_addr[7:0] == 8'h01)  answer = DEV_CODE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en && id_mode;
      rd_data  <= (rd_en && id_mode) ? answer : '0;
    end
  end

  // R8: no answer is given outside identification mode
  assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !id_mode) |=> (!rd_valid && rd_data == '0));

  // R8: offset 01 always returns the device code
  assert_devcode_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && id_mode && rd_addr[7:0] == 8'h01) |=> (rd_valid && rd_data == DEV_CODE));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int               ADDR_W   = 17,
  parameter int               PAGE_AW  = 12,
  parameter int               BOOT_AW  = 14,
  parameter logic [7:0]       MFR_CODE = 8'hDA,
  parameter logic [7:0]       DEV_CODE = 8'hA1,
  localparam int              NPAGE    = 1 << (ADDR_W - PAGE_AW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              prog_start,
  output logic              chip_erase_start,
  output logic              page_erase_start,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic [NPAGE-1:0]  erase_mask,
  output logic              id_mode,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);
  seq_evt_t evt;
  logic     lock_top, lock_bot;

  fcs_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .evt(evt), .id_mode(id_mode)
  );

  fcs_guard #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW), .BOOT_AW(BOOT_AW)) u_guard (
    .clk(clk), .rst(rst), .lock_clr(lock_clr), .evt(evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .prog_start(prog_start), .chip_start(chip_erase_start),
    .page_start(page_erase_start), .op_addr(op_addr), .op_data(op_data),
    .erase_mask(erase_mask), .lock_top(lock_top), .lock_bot(lock_bot)
  );

  fcs_idread #(.ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_idread (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .id_mode(id_mode),
    .lock_top(lock_top), .lock_bot(lock_bot), .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1, lock_clr = 1'b1;
  logic        wr_en = 1'b0, busy = 1'b0, rd_en = 1'b0;
  logic [16:0] wr_addr = '0, rd_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        prog_start, chip_erase_start, page_erase_start, id_mode, rd_valid;
  logic [16:0] op_addr;
  logic [7:0]  op_data, rd_data;
  logic [31:0] erase_mask;

  int  n_chk = 0, n_err = 0;
  bit  done = 1'b0;
  bit  mlt = 1'b0, mlb = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst(rst), .lock_clr(lock_clr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr),
    .prog_start(prog_start), .chip_erase_start(chip_erase_start),
    .page_erase_start(page_erase_start), .op_addr(op_addr), .op_data(op_data),
    .erase_mask(erase_mask), .id_mode(id_mode), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit page_locked(input logic [16:0] a, input bit lt, input bit lb);
    return (lb && a[16:12] < 5'd4) || (lt && a[16:12] >= 5'd28);
  endfunction

  function automatic logic [31:0] chip_mask(input bit lt, input bit lb);
    logic [31:0] m;
    for (int p = 0; p < 32; p++)
      m[p] = !((lb && p < 4) || (lt && p >= 28));
    return m;
  endfunction

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [16:0] a);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wrrd(input logic [16:0] a, input logic [7:0] d, input logic [16:0] ra);
    wr_en = 1'b1; wr_addr = a; wr_data = d; rd_en = 1'b1; rd_addr = ra;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic unlock();
    wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h55);
  endtask

  task automatic erase_prefix();
    unlock(); wr(17'h05555, 8'h80); unlock();
  endtask

  task automatic pulses(input bit ep, input bit ec, input bit eg, input string tag);
    check({prog_start, chip_erase_start, page_erase_start} == {ep, ec, eg}, tag,
          {29'd0, prog_start, chip_erase_start, page_erase_start}, {29'd0, ep, ec, eg});
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    report();
  end

  initial begin
    logic [16:0] ca [6];
    logic [7:0]  cd [6];
    repeat (3) @(negedge clk);
    rst = 1'b0; lock_clr = 1'b0;

    // R1: reset state
    check(!prog_start && !chip_erase_start && !page_erase_start, "R1 pulses", 0, 0);
    check(!id_mode && !rd_valid && rd_data == 0, "R1 id/read", {id_mode, rd_valid, rd_data}, 0);
    check(op_addr == 0 && erase_mask == 0, "R1 op regs", erase_mask, 0);
    wr(17'h00100, 8'h12);
    pulses(0, 0, 0, "R1 lone data write");

    // R2: byte program with aliased command addresses
    unlock(); wr(17'h05555, 8'hA0); wr(17'h12345, 8'h5A);
    pulses(1, 0, 0, "R2 program pulse");
    check(op_addr == 17'h12345 && op_data == 8'h5A, "R2 op addr/data",
          {op_addr, op_data}, {17'h12345, 8'h5A});
    @(negedge clk);
    pulses(0, 0, 0, "R13 pulse one cycle");
    wr(17'h1D555, 8'hAA); wr(17'h0AAAA, 8'h55); wr(17'h15555, 8'hA0); wr(17'h04000, 8'h3C);
    pulses(1, 0, 0, "R2 aliased addresses");

    // R3: chip erase, no locks
    erase_prefix(); wr(17'h05555, 8'h10);
    pulses(0, 1, 0, "R3 chip pulse");
    check(erase_mask == 32'hFFFF_FFFF && op_addr == 0, "R3 full mask", erase_mask, 32'hFFFF_FFFF);

    // R4: page erase
    erase_prefix(); wr(17'h0A123, 8'h50);
    pulses(0, 0, 1, "R4 page pulse");
    check(erase_mask == 32'h0000_0400 && op_addr == 17'h0A123, "R4 mask", erase_mask, 32'h400);

    // R6: wrong data in second cycle aborts
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h56); wr(17'h05555, 8'hA0); wr(17'h00100, 8'h12);
    pulses(0, 0, 0, "R6 bad unlock");
    // R6: wrong address in third cycle aborts
    unlock(); wr(17'h05554, 8'hA0); wr(17'h00100, 8'h12);
    pulses(0, 0, 0, "R6 bad command address");

    // R7: write during busy ignored
    unlock(); wr(17'h05555, 8'hA0);
    busy = 1'b1; wr(17'h05000, 8'h11); busy = 1'b0;
    pulses(0, 0, 0, "R7 busy write ignored");
    wr(17'h05000, 8'h22);
    pulses(1, 0, 0, "R7 sequence kept across busy");
    check(op_data == 8'h22, "R7 data after busy", op_data, 8'h22);

    // R5: bad seventh address sets nothing; bottom lock
    erase_prefix(); wr(17'h05555, 8'h70); wr(17'h00100, 8'h00);
    erase_prefix(); wr(17'h05555, 8'h70); wr(17'h00000, 8'h00);
    mlb = 1'b1;

    // R8: identification entry and codes
    unlock(); wr(17'h05555, 8'h90);
    check(id_mode == 1'b1, "R8 id entry", id_mode, 1);
    rd(17'h12300);
    check(rd_valid && rd_data == 8'hDA, "R8 mfr code", rd_data, 8'hDA);
    rd(17'h00001);
    check(rd_valid && rd_data == 8'hA1, "R8 dev code", rd_data, 8'hA1);
    rd(17'h00055);
    check(rd_valid && rd_data == 8'h00, "R8 other addr", rd_data, 0);
    // R9 / R5: bottom set, top still clear (bad seventh address had no effect)
    rd(17'h00002);
    check(rd_data == 8'h03, "R9 bottom status", rd_data, 3);
    rd(17'h1FFF2);
    check(rd_data == 8'h00, "R5 bad seventh addr no top lock", rd_data, 0);
    // R9: top lock write and status read in one cycle
    erase_prefix(); wr(17'h05555, 8'h70); wrrd(17'h1FFFF, 8'h00, 17'h1FFF2);
    mlt = 1'b1;
    check(rd_valid && rd_data == 8'h00, "R9 same-cycle read sees old lock", rd_data, 0);
    rd(17'h1FFF2);
    check(rd_data == 8'h03, "R5 top lock set", rd_data, 3);
    // R10: single-write exit with a read in the same cycle
    wrrd(17'h00777, 8'hF0, 17'h00000);
    check(rd_valid && rd_data == 8'hDA, "R10 read on exit cycle", rd_data, 8'hDA);
    check(!id_mode, "R10 single-write exit", id_mode, 0);
    rd(17'h00000);
    check(!rd_valid && rd_data == 0, "R8 no answer outside id", rd_valid, 0);
    // R10: three-cycle exit
    unlock(); wr(17'h05555, 8'h90); unlock(); wr(17'h05555, 8'hF0);
    check(!id_mode, "R10 three-cycle exit", id_mode, 0);

    // R11: protection
    unlock(); wr(17'h05555, 8'hA0); wr(17'h01000, 8'h00);
    pulses(0, 0, 0, "R11 program bottom locked");
    erase_prefix(); wr(17'h1E000, 8'h50);
    pulses(0, 0, 0, "R11 page erase top locked");
    erase_prefix(); wr(17'h05555, 8'h10);
    pulses(0, 1, 0, "R3 chip with locks");
    check(erase_mask == 32'h0FFF_FFF0, "R3 skip locked pages", erase_mask, 32'h0FFF_FFF0);

    // R12: locks survive rst, clear only by lock_clr
    unlock(); wr(17'h05555, 8'h90);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check(!id_mode, "R1 reset clears id mode", id_mode, 0);
    unlock(); wr(17'h05555, 8'h90); rd(17'h00002);
    check(rd_data == 8'h03, "R12 lock kept over reset", rd_data, 3);
    lock_clr = 1'b1; @(negedge clk); lock_clr = 1'b0;
    mlt = 1'b0; mlb = 1'b0;
    rd(17'h00002);
    check(rd_data == 8'h00, "R12 lock_clr clears", rd_data, 0);
    wr(17'h00000, 8'hF0);

    // Random phase
    void'($urandom(32'd2024));
    erase_prefix(); wr(17'h05555, 8'h70); wr(17'h00000, 8'h00);
    mlb = 1'b1;
    for (int it = 0; it < 160; it++) begin
      int kind, n, ck, sk;
      bit corrupt, stall, ep, ec, eg;
      logic [16:0] a;
      logic [7:0] d;
      if (it == 80) begin
        erase_prefix(); wr(17'h05555, 8'h70); wr(17'h1FFFF, 8'h00);
        mlt = 1'b1;
      end
      kind = int'($urandom % 3);
      a = 17'($urandom);
      d = 8'($urandom);
      if (d == 8'hAA) d = 8'hAB;
      n = (kind == 0) ? 4 : 6;
      corrupt = ($urandom % 4) == 0;
      stall = ($urandom % 3) == 0;
      ck = int'($urandom % (n - 1));
      sk = int'($urandom % n);
      ca[0] = 17'h05555; cd[0] = 8'hAA;
      ca[1] = 17'h02AAA; cd[1] = 8'h55;
      ca[2] = 17'h05555; cd[2] = (kind == 0) ? 8'hA0 : 8'h80;
      ca[3] = (kind == 0) ? a : 17'h05555; cd[3] = (kind == 0) ? d : 8'hAA;
      ca[4] = 17'h02AAA; cd[4] = 8'h55;
      ca[5] = (kind == 1) ? 17'h05555 : a; cd[5] = (kind == 1) ? 8'h10 : 8'h50;
      for (int i = 0; i < n; i++) begin
        if (stall && i == sk) begin
          busy = 1'b1; wr(17'h05555, 8'hAA); busy = 1'b0;
        end
        wr(ca[i], (corrupt && i == ck) ? 8'h33 : cd[i]);
      end
      ep = (kind == 0) && !corrupt && !page_locked(a, mlt, mlb);
      ec = (kind == 1) && !corrupt;
      eg = (kind == 2) && !corrupt && !page_locked(a, mlt, mlb);
      pulses(ep, ec, eg, corrupt ? "R6 random abort" : "R11 random command");
      if (ep) check(op_addr == a && op_data == d, "R2 random program",
                    {op_addr, op_data}, {a, d});
      if (ec) check(erase_mask == chip_mask(mlt, mlb), "R3 random chip mask",
                    erase_mask, chip_mask(mlt, mlb));
      if (eg) check(erase_mask == (32'd1 << a[16:12]), "R4 random page mask",
                    erase_mask, 32'd1 << a[16:12]);
      wr(17'h00000, 8'h33);
    end
    report();
  end
endmodule